// File: doc/BRIEF.md
# Bus-Based Microprogrammed Datapath Slice

This block is the execution slice of a small microcoded stack-machine interpreter. A bank of general 32-bit registers shares one operand bus (the B bus). A separate holding register feeds the ALU's other operand. The ALU result goes through a two-function shifter onto the result bus (the C bus), and from there it can be written back into any set of registers, the holding register included, at the same clock edge.

An 8-bit read-only byte register, loaded from a test port, can take over the B bus. It widens its value either with the sign copied or with zeros. All control comes in as one flat word per cycle: an encoded B source, a one-hot-per-register destination mask, the ALU function and gating bits, and the shift controls. The result bus value, the N and Z flags and two illegal-encoding flags appear as registered outputs one cycle later. A register's contents are read by routing it through the ALU unchanged.

Top module: `bus_datapath`

## Requirements
- R1: Synchronous active-high reset clears every general register, the holding register, the byte register and all registered outputs.
- R2: While neither byte enable is set, the general register whose index equals `b_sel` alone drives the B bus.
- R3: Bit i of `c_mask` (i below NREGS) writes the C bus value into register i, and bit NREGS writes the holding register. Any number of bits may be set in one cycle, and they all receive the same value. Registers whose bit is clear keep their contents.
- R4: `byte_ld` loads `byte_din` into the byte register. When only `byte_sx_en` is set, the B bus carries the byte with bit 7 copied into bits 31:8. When only `byte_zx_en` is set, the B bus carries the byte with bits 31:8 cleared. In both cases `b_sel` is ignored.
- R5: When both byte enables are set, the B bus is zero and `byte_err_q` is 1 in the next cycle. Otherwise `byte_err_q` is 0.
- R6: ALU operand A is the holding register if `alu_ena` is set, else 0, and it is bitwise inverted when `alu_inva` is set. Operand B is the B bus if `alu_enb` is set, else 0. `alu_fn` selects the result: 0 = A AND B, 1 = A OR B, 2 = NOT B, 3 = A + B + `alu_inc`, modulo 2^32. `alu_inc` has no effect for the other codes.
- R7: `sh_sll8` alone shifts the ALU result left logically by 8. `sh_sra1` alone shifts it right arithmetically by 1. With neither set, the result passes unchanged.
- R8: When both shift controls are set, the ALU result passes unshifted and `shift_err_q` is 1 in the next cycle. Otherwise `shift_err_q` is 0.
- R9: `n_q` is bit 31 and `z_q` is the all-zero test of the ALU result before the shifter.
- R10: Register read, ALU, shift and write-back all take one cycle. The outputs change only at the clock edge that follows the controls, and a register written at an edge can be read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| b_sel | input | SELW (3) | Encoded general-register source for the B bus |
| byte_sx_en | input | 1 | Byte register drives B bus, sign-extended |
| byte_zx_en | input | 1 | Byte register drives B bus, zero-extended |
| c_mask | input | NREGS+1 (9) | Write-back mask; top bit is the holding register |
| alu_fn | input | 2 | ALU function code |
| alu_ena | input | 1 | Pass holding register as operand A |
| alu_enb | input | 1 | Pass B bus as operand B |
| alu_inva | input | 1 | Invert operand A |
| alu_inc | input | 1 | Carry-in for the add |
| sh_sll8 | input | 1 | Logical left shift by 8 |
| sh_sra1 | input | 1 | Arithmetic right shift by 1 |
| byte_ld | input | 1 | Load strobe for the byte register (test port) |
| byte_din | input | BW (8) | Byte register load data |
| c_q | output | DW (32) | Registered C bus value |
| n_q | output | 1 | Registered negative flag |
| z_q | output | 1 | Registered zero flag |
| byte_err_q | output | 1 | Both byte enables were set |
| shift_err_q | output | 1 | Both shift controls were set |

## Verification
The only state is the register bank, the holding register and the byte register. Corruption of any of them shows up on `c_q` one cycle after that register is routed to the B bus, or through operand A. A write mask that decodes wrongly, whether it misses a register or also writes a neighbour, stays hidden until the affected register is read back. For that reason the sequence reads back written and unwritten registers many cycles later. Flag and error faults show up in the same cycle as the `c_q` value they belong to.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [1:0] {
    ALU_AND  = 2'd0,
    ALU_OR   = 2'd1,
    ALU_NOTB = 2'd2,
    ALU_ADD  = 2'd3
  } alu_fn_e;

  typedef struct packed {
    alu_fn_e fn;
    logic    ena;
    logic    enb;
    logic    inva;
    logic    inc;
  } alu_ctl_t;

endpackage

// File: rtl/dp_regbank.sv
module dp_regbank #(
  parameter int DW    = 32,
  parameter int NREGS = 8,
  parameter int SELW  = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SELW-1:0]  rd_sel,
  output logic [DW-1:0]    rd_data,
  input  logic [NREGS-1:0] wr_mask,
  input  logic [DW-1:0]    wr_data
);

  logic [DW-1:0] regs [NREGS];

  // one write port per register so any subset can load the same value
  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)              regs[gi] <= '0;
      else if (wr_mask[gi]) regs[gi] <= wr_data;
    end
  end

  // single encoded source: exactly one register can reach the bus
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rd_sel == SELW'(i)) rd_data = regs[i];
    end
  end

endmodule

// File: rtl/dp_bytereg.sv
module dp_bytereg #(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [BW-1:0] din,
  input  logic          sx_en,
  input  logic          zx_en,
  output logic          drive,
  output logic          err,
  output logic [DW-1:0] bus
);

  localparam int EXTW = DW - BW;

  logic [BW-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst)     byte_q <= '0;
    else if (ld) byte_q <= din;
  end

  assign drive = sx_en | zx_en;
  assign err   = sx_en & zx_en;

  always_comb begin
    if (err)        bus = '0;
    else if (sx_en) bus = {{EXTW{byte_q[BW-1]}}, byte_q};
    else            bus = {{EXTW{1'b0}}, byte_q};
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  alu_ctl_t      ctl,
  output logic [DW-1:0] y,
  output logic          neg,
  output logic          zero
);

  logic [DW-1:0] opa;
  logic [DW-1:0] opb;

  always_comb begin
    opa = ctl.ena ? a_in : '0;
    if (ctl.inva) opa = ~opa;
    opb = ctl.enb ? b_in : '0;
    unique case (ctl.fn)
      ALU_AND:  y = opa & opb;
      ALU_OR:   y = opa | opb;
      ALU_NOTB: y = ~opb;
      default:  y = opa + opb + {{(DW-1){1'b0}}, ctl.inc};
    endcase
  end

  assign neg  = y[DW-1];
  assign zero = (y == '0);

endmodule

// File: rtl/dp_shifter.sv
module dp_shifter #(
  parameter int DW   = 32,
  parameter int LSH  = 8
) (
  input  logic [DW-1:0] d,
  input  logic          sll,
  input  logic          sra,
  output logic [DW-1:0] q,
  output logic          err
);

  assign err = sll & sra;

  always_comb begin
    if (err)      q = d;
    else if (sll) q = {d[DW-LSH-1:0], {LSH{1'b0}}};
    else if (sra) q = {d[DW-1], d[DW-1:1]};
    else          q = d;
  end

endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
  import dp_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREGS = 8,
  parameter int BW    = 8,
  parameter int SELW  = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SELW-1:0]  b_sel,
  input  logic             byte_sx_en,
  input  logic             byte_zx_en,
  input  logic [NREGS:0]   c_mask,
  input  logic [1:0]       alu_fn,
  input  logic             alu_ena,
  input  logic             alu_enb,
  input  logic             alu_inva,
  input  logic             alu_inc,
  input  logic             sh_sll8,
  input  logic             sh_sra1,
  input  logic             byte_ld,
  input  logic [BW-1:0]    byte_din,
  output logic [DW-1:0]    c_q,
  output logic             n_q,
  output logic             z_q,
  output logic             byte_err_q,
  output logic             shift_err_q
);

  localparam int HOLD_BIT = NREGS;

  logic [DW-1:0] h_q;
  logic [DW-1:0] b_reg;
  logic [DW-1:0] b_byte;
  logic [DW-1:0] b_bus;
  logic [DW-1:0] alu_y;
  logic [DW-1:0] c_bus;
  logic          byte_drv;
  logic          byte_err;
  logic          sh_err;
  logic          alu_n;
  logic          alu_z;
  alu_ctl_t      actl;

  dp_regbank #(.DW(DW), .NREGS(NREGS), .SELW(SELW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .rd_sel  (b_sel),
    .rd_data (b_reg),
    .wr_mask (c_mask[NREGS-1:0]),
    .wr_data (c_bus)
  );

  dp_bytereg #(.DW(DW), .BW(BW)) u_byte (
    .clk   (clk),
    .rst   (rst),
    .ld    (byte_ld),
    .din   (byte_din),
    .sx_en (byte_sx_en),
    .zx_en (byte_zx_en),
    .drive (byte_drv),
    .err   (byte_err),
    .bus   (b_byte)
  );

  assign b_bus = byte_drv ? b_byte : b_reg;

  always_ff @(posedge clk) begin
    if (rst)                 h_q <= '0;
    else if (c_mask[HOLD_BIT]) h_q <= c_bus;
  end

  always_comb begin
    actl.fn   = alu_fn_e'(alu_fn);
    actl.ena  = alu_ena;
    actl.enb  = alu_enb;
    actl.inva = alu_inva;
    actl.inc  = alu_inc;
  end

  dp_alu #(.DW(DW)) u_alu (
    .a_in (h_q),
    .b_in (b_bus),
    .ctl  (actl),
    .y    (alu_y),
    .neg  (alu_n),
    .zero (alu_z)
  );

  dp_shifter #(.DW(DW), .LSH(BW)) u_shift (
    .d   (alu_y),
    .sll (sh_sll8),
    .sra (sh_sra1),
    .q   (c_bus),
    .err (sh_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q         <= '0;
      n_q         <= 1'b0;
      z_q         <= 1'b0;
      byte_err_q  <= 1'b0;
      shift_err_q <= 1'b0;
    end else begin
      c_q         <= c_bus;
      n_q         <= alu_n;
      z_q         <= alu_z;
      byte_err_q  <= byte_err;
      shift_err_q <= sh_err;
    end
  end

endmodule

// File: rtl/bus_datapath_chk.sv
module bus_datapath_chk #(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          byte_sx_en,
  input logic          byte_zx_en,
  input logic [1:0]    alu_fn,
  input logic          alu_ena,
  input logic          alu_enb,
  input logic          sh_sll8,
  input logic          sh_sra1,
  input logic [DW-1:0] c_q,
  input logic          n_q,
  input logic          z_q,
  input logic          byte_err_q,
  input logic          shift_err_q
);

  AST_BYTE_BOTH_FLAG: assert property (@(posedge clk) disable iff (rst)
    (byte_sx_en && byte_zx_en) |=> byte_err_q);                         // R5

  AST_BYTE_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(byte_sx_en && byte_zx_en) |=> !byte_err_q);                       // R5

  AST_SHIFT_BOTH_FLAG: assert property (@(posedge clk) disable iff (rst)
    (sh_sll8 && sh_sra1) |=> shift_err_q);                              // R8

  AST_SHIFT_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(sh_sll8 && sh_sra1) |=> !shift_err_q);                            // R8

  AST_SLL_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sh_sll8 && !sh_sra1) |=> (c_q[BW-1:0] == '0));                     // R7

  AST_SRA_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (sh_sra1 && !sh_sll8) |=> (c_q[DW-1] == c_q[DW-2]));                // R7

  AST_FLAGS_MATCH_C: assert property (@(posedge clk) disable iff (rst)
    (!sh_sll8 && !sh_sra1) |=> (z_q == (c_q == '0)) && (n_q == c_q[DW-1])); // R9

  AST_ZX_HIGH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (byte_zx_en && !byte_sx_en && alu_enb && !alu_ena && alu_fn == 2'd1
     && !sh_sll8 && !sh_sra1) |=> (c_q[DW-1:BW] == '0));                // R4

endmodule

bind bus_datapath bus_datapath_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .byte_sx_en  (byte_sx_en),
  .byte_zx_en  (byte_zx_en),
  .alu_fn      (alu_fn),
  .alu_ena     (alu_ena),
  .alu_enb     (alu_enb),
  .sh_sll8     (sh_sll8),
  .sh_sra1     (sh_sra1),
  .c_q         (c_q),
  .n_q         (n_q),
  .z_q         (z_q),
  .byte_err_q  (byte_err_q),
  .shift_err_q (shift_err_q)
);

// File: tb/bus_datapath_tb.sv
`timescale 1ns/1ps
module bus_datapath_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  b_sel;
  logic        byte_sx_en, byte_zx_en;
  logic [8:0]  c_mask;
  logic [1:0]  alu_fn;
  logic        alu_ena, alu_enb, alu_inva, alu_inc;
  logic        sh_sll8, sh_sra1;
  logic        byte_ld;
  logic [7:0]  byte_din;
  logic [31:0] c_q;
  logic        n_q, z_q, byte_err_q, shift_err_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_datapath u_dut (
    .clk(clk), .rst(rst), .b_sel(b_sel), .byte_sx_en(byte_sx_en),
    .byte_zx_en(byte_zx_en), .c_mask(c_mask), .alu_fn(alu_fn),
    .alu_ena(alu_ena), .alu_enb(alu_enb), .alu_inva(alu_inva),
    .alu_inc(alu_inc), .sh_sll8(sh_sll8), .sh_sra1(sh_sra1),
    .byte_ld(byte_ld), .byte_din(byte_din), .c_q(c_q), .n_q(n_q),
    .z_q(z_q), .byte_err_q(byte_err_q), .shift_err_q(shift_err_q)
  );

  typedef struct packed {
    logic [2:0]  bsel;
    logic        sx, zx;
    logic [8:0]  mask;
    logic [1:0]  fn;
    logic        ena, enb, inva, inc, sll, sra;
    logic [31:0] c;
    logic        n, z, berr, serr;
    logic [3:0]  req;
  } vec_t;

  // fn: 0 AND, 1 OR, 2 NOT B, 3 ADD; mask bit 8 = holding register
  // state entering the table: all registers 0, byte register = 0x85
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{3'd0,1'b1,1'b0,9'h009,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'hFFFFFF85,1'b1,1'b0,1'b0,1'b0,4'd4}, // R4 sx, R3 r0+r3
    '{3'd0,1'b0,1'b1,9'h100,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h00000085,1'b0,1'b0,1'b0,1'b0,4'd4}, // R4 zx overrides b_sel
    '{3'd0,1'b0,1'b0,9'h000,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'hFFFFFF85,1'b1,1'b0,1'b0,1'b0,4'd3}, // R3 r0
    '{3'd3,1'b0,1'b0,9'h000,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'hFFFFFF85,1'b1,1'b0,1'b0,1'b0,4'd2}, // R2 r3 multi-write
    '{3'd0,1'b0,1'b0,9'h002,2'd3,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0000000A,1'b0,1'b0,1'b0,1'b0,4'd6}, // R6 add wrap
    '{3'd1,1'b0,1'b0,9'h004,2'd3,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,32'h00000090,1'b0,1'b0,1'b0,1'b0,4'd6}, // R6 add+inc
    '{3'd0,1'b0,1'b0,9'h000,2'd0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h00000085,1'b0,1'b0,1'b0,1'b0,4'd6}, // R6 and
    '{3'd2,1'b0,1'b0,9'h000,2'd2,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'hFFFFFF6F,1'b1,1'b0,1'b0,1'b0,4'd6}, // R6 not b
    '{3'd0,1'b0,1'b0,9'h000,2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,32'hFFFFFF7A,1'b1,1'b0,1'b0,1'b0,4'd6}, // R6 inva
    '{3'd0,1'b0,1'b0,9'h010,2'd3,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,32'hFFFFFF7B,1'b1,1'b0,1'b0,1'b0,4'd6}, // R6 negate
    '{3'd1,1'b0,1'b0,9'h000,2'd1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h00000A00,1'b0,1'b0,1'b0,1'b0,4'd7}, // R7 sll8
    '{3'd4,1'b0,1'b0,9'h000,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,32'hFFFFFFBD,1'b1,1'b0,1'b0,1'b0,4'd7}, // R7 sra1 neg
    '{3'd2,1'b0,1'b0,9'h000,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,32'h00000048,1'b0,1'b0,1'b0,1'b0,4'd7}, // R7 sra1 pos
    '{3'd1,1'b0,1'b0,9'h000,2'd1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0000000A,1'b0,1'b0,1'b0,1'b1,4'd8}, // R8 both shifts
    '{3'd0,1'b0,1'b0,9'h008,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h00000000,1'b0,1'b1,1'b0,1'b0,4'd9}, // R9 zero, overwrite r3
    '{3'd3,1'b0,1'b0,9'h000,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h00000000,1'b0,1'b1,1'b0,1'b0,4'd3}, // R3 r3 overwritten
    '{3'd0,1'b0,1'b0,9'h000,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h00000085,1'b0,1'b0,1'b0,1'b0,4'd3}, // R3 holding kept
    '{3'd2,1'b1,1'b1,9'h000,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h00000000,1'b0,1'b1,1'b1,1'b0,4'd5}, // R5 both byte en
    '{3'd0,1'b0,1'b0,9'h000,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'hFFFFFFFF,1'b1,1'b0,1'b0,1'b0,4'd6}, // R6 not 0
    '{3'd0,1'b0,1'b0,9'h000,2'd1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,32'hFFFF8500,1'b1,1'b0,1'b0,1'b0,4'd7}, // R7 sll8 neg
    '{3'd0,1'b0,1'b0,9'h000,2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'hFFFFFF85,1'b1,1'b0,1'b0,1'b0,4'd3}, // R3 r0 untouched
    '{3'd0,1'b0,1'b0,9'h000,2'd3,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,32'h00000000,1'b0,1'b0,1'b0,1'b0,4'd9}  // R9 pre-shift flags
  };

  task automatic idle();
    b_sel = '0; byte_sx_en = 0; byte_zx_en = 0; c_mask = '0; alu_fn = 2'd0;
    alu_ena = 0; alu_enb = 0; alu_inva = 0; alu_inc = 0;
    sh_sll8 = 0; sh_sra1 = 0; byte_ld = 0; byte_din = '0;
  endtask

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got c=%h n/z/be/se=%b expected c=%h n/z/be/se=%b",
               tag, act[35:4], act[3:0], exp[35:4], exp[3:0]);
    end
  endtask

  function automatic logic [35:0] outs();
    return {c_q, n_q, z_q, byte_err_q, shift_err_q};
  endfunction

  task automatic read_reg(input logic [2:0] r, input logic hold);
    idle();
    b_sel = r; alu_fn = 2'd1; alu_enb = !hold; alu_ena = hold;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", outs(), 36'h0);
    rst = 1'b0;

    // load byte register through the test port
    byte_ld = 1'b1; byte_din = 8'h85;
    @(negedge clk);
    check("R4 load cycle idle", outs(), {32'h0, 4'b0100});

    for (int i = 0; i < NV; i++) begin
      idle();
      b_sel = VEC[i].bsel; byte_sx_en = VEC[i].sx; byte_zx_en = VEC[i].zx;
      c_mask = VEC[i].mask; alu_fn = VEC[i].fn; alu_ena = VEC[i].ena;
      alu_enb = VEC[i].enb; alu_inva = VEC[i].inva; alu_inc = VEC[i].inc;
      sh_sll8 = VEC[i].sll; sh_sra1 = VEC[i].sra;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), outs(),
            {VEC[i].c, VEC[i].n, VEC[i].z, VEC[i].berr, VEC[i].serr});
    end

    // R10: output holds until the edge after the controls, then updates
    idle();
    b_sel = 3'd0; alu_fn = 2'd1; alu_enb = 1'b1;
    #3;
    check("R10 before edge", outs(), {32'h0, 4'b0000});
    @(negedge clk);
    check("R10 after edge", outs(), {32'hFFFFFF85, 4'b1000});

    // R10: write at one edge, read back at the next
    idle();
    alu_fn = 2'd2; c_mask = 9'h040;
    @(negedge clk);
    read_reg(3'd6, 1'b0);
    check("R10 write then read r6", outs(), {32'hFFFFFFFF, 4'b1000});

    // R1: reset clears register bank, holding and byte registers
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 outputs after reset", outs(), 36'h0);
    read_reg(3'd0, 1'b0);
    check("R1 r0 cleared", outs(), {32'h0, 4'b0100});
    read_reg(3'd0, 1'b1);
    check("R1 holding cleared", outs(), {32'h0, 4'b0100});
    idle();
    byte_sx_en = 1'b1; alu_fn = 2'd1; alu_enb = 1'b1;
    @(negedge clk);
    check("R1 byte register cleared", outs(), {32'h0, 4'b0100});

    finish_run();
  end

endmodule